// File: doc/BRIEF.md
# Interprocessor and Interval Timer Interrupt Controller

This block holds a 64-bit control/status word for a four-processor system, together with four per-processor interval ignore counters. Software raises and clears interprocessor interrupts and acknowledges interval timer interrupts through the control word. Each field of that word has its own write rule: clear-on-one, set-on-one, set-on-one only while the field is zero, or a write that sets another field. The word also carries two arbitration fields, a plain read/write user nibble and a fixed revision bit.

A periodic timer tick comes from outside the block. On each rising edge of the tick, every ignore counter counts down by one. While a counter's sticky overflow bit is set, that processor's timer flag is set and its timer interrupt output is raised. Software loads a counter to skip that many ticks before the interrupt starts firing. Reads return the index of the requesting processor in the lowest bits of the control word.

Top module: `ipi_timer_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0008_0000_0000 (revision bit 35 set) with the requester index in bits 1:0. All four counters read 0 and both interrupt outputs are 0.
- R2: A read of the control word (offset 0x080) places `req_cpu` in bits 1:0. Bits 43:40 take the written value on every control write and read back unchanged.
- R3: A control write clears every stored bit among bits 11:4 and bit 28 for which the written data has a 1. Bits 7:4 are the timer flags of processors 0..3 and bits 11:8 are their interprocessor flags.
- R4: A control write with bit 20 set first clears bits 23:16. Bits 23:20 are then set wherever the data has a 1.
- R5: Bits 19:16 take the written ones only when, after the R4 step, they hold zero. Otherwise they are left as they are.
- R6: Data ones in bits 15:12 set the interprocessor flags 11:8. On the same bit this set overrides an R3 clear. `ipi_irq[i]` equals flag bit 8+i from the cycle after the write.
- R7: A control write can lower `tmr_irq[i]`, by clearing flag bit 4+i, and can never raise it.
- R8: The counters of processors 0..3 sit at offsets 0x380, 0x3C0, 0x700 and 0x740. A write stores data bits 23:0 and clears the read-only overflow bit 24. Reads return the 25-bit value zero-extended.
- R9: On each rising edge of `tick_in` every counter counts down modulo 2^25 and keeps bit 24 once it is set. When the new bit 24 is 1, flag bit 4+i and `tmr_irq[i]` are set on the same clock edge.
- R10: A falling edge of `tick_in`, or a level held high, neither changes a counter nor raises a timer interrupt.
- R11: Writes to unmapped offsets change nothing, and reads of them return 0. A counter write in the same cycle as a tick edge takes priority for that counter, and that counter does not fire on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe for one cycle |
| csr_addr | input | 12 | Register offset for reads and writes |
| csr_wdata | input | 64 | Write data |
| req_cpu | input | 2 | Index of the requesting processor, returned on control reads |
| csr_rdata | output | 64 | Combinational read data for `csr_addr` |
| tick_in | input | 1 | Periodic interval timer tick level |
| ipi_irq | output | 4 | Interprocessor interrupt per processor |
| tmr_irq | output | 4 | Interval timer interrupt per processor |

## Verification
Control writes combine clear and set bits in one word, for example clearing and setting the same interprocessor flag. The arbitration fields are written with a nonzero and then a zero low field, so the conditional set is told apart from a plain set. The tick input is driven as one-cycle pulses, as a level held high for several cycles and as a falling edge, which separates edge detection from level sensing. The counters are loaded so that one overflows while the others do not, which shows that bit 24 stays set and the flag is per processor. A counter write that lands on a tick edge checks which of the two updates wins.

// File: rtl/itc_pkg.sv
package itc_pkg;
    localparam int ADDR_W   = 12;
    localparam int XLEN     = 64;
    localparam int CPU_CNT  = 4;
    localparam int IGN_W    = 24;

    // control word field positions (software decodes these)
    localparam int TMR_LSB  = 4;
    localparam int IPI_LSB  = 8;
    localparam int IPR_LSB  = 12;
    localparam int ARBW_LSB = 16;
    localparam int ARBT_LSB = 20;
    localparam int ARB_CLR  = 20;
    localparam int USR_LSB  = 40;
    localparam int ARB_W    = 4;
    localparam int USR_W    = 4;

    localparam logic [XLEN-1:0] W1C_MASK = 64'h0000_0000_1000_0FF0;
    localparam logic [XLEN-1:0] CTL_INIT = 64'h0000_0008_0000_0000;

    localparam logic [ADDR_W-1:0] CTL_OFS = 12'h080;

    function automatic logic [ADDR_W-1:0] ign_ofs(input int idx);
        case (idx)
            0:       return 12'h380;
            1:       return 12'h3C0;
            2:       return 12'h700;
            default: return 12'h740;
        endcase
    endfunction
endpackage

// File: rtl/itc_ign_cnt.sv
module itc_ign_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    output logic [CNT_W:0]   cnt_o,
    output logic             fire_o
);
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;
    logic [CW-1:0] dec_v;

    always_comb begin
        cnt_d         = cnt_q;
        fire_o        = 1'b0;
        dec_v         = cnt_q.cnt - CW'(1);
        dec_v[CNT_W]  = dec_v[CNT_W] | cnt_q.cnt[CNT_W];
        if (wr_en) begin
            cnt_d.cnt = {1'b0, wdata};
        end else if (step) begin
            cnt_d.cnt = dec_v;
            fire_o    = dec_v[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q.cnt;
endmodule

// File: rtl/itc_ctl_reg.sv
module itc_ctl_reg
    import itc_pkg::*;
#(
    parameter int NCPU = CPU_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    input  logic [NCPU-1:0] fire,
    output logic [XLEN-1:0] word_o,
    output logic [NCPU-1:0] ipi_o,
    output logic [NCPU-1:0] tmr_o
);
    typedef struct packed {
        logic [XLEN-1:0] word;
        logic [NCPU-1:0] tmr;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = st_d.word & ~(W1C_MASK & wdata);
            if (wdata[ARB_CLR]) begin
                st_d.word[ARBW_LSB +: 2*ARB_W] = '0;
            end
            st_d.word[ARBT_LSB +: ARB_W] = st_d.word[ARBT_LSB +: ARB_W] | wdata[ARBT_LSB +: ARB_W];
            if (st_d.word[ARBW_LSB +: ARB_W] == '0) begin
                st_d.word[ARBW_LSB +: ARB_W] = wdata[ARBW_LSB +: ARB_W];
            end
            st_d.word[IPI_LSB +: NCPU] = st_d.word[IPI_LSB +: NCPU] | wdata[IPR_LSB +: NCPU];
            st_d.word[USR_LSB +: USR_W] = wdata[USR_LSB +: USR_W];
            for (int i = 0; i < NCPU; i++) begin
                if (!st_d.word[TMR_LSB + i]) st_d.tmr[i] = 1'b0;
            end
        end
        for (int i = 0; i < NCPU; i++) begin
            if (fire[i]) begin
                st_d.word[TMR_LSB + i] = 1'b1;
                st_d.tmr[i]            = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= CTL_INIT;
            st_q.tmr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign ipi_o  = st_q.word[IPI_LSB +: NCPU];
    assign tmr_o  = st_q.tmr;
endmodule

// File: rtl/ipi_timer_ctrl.sv
module ipi_timer_ctrl
    import itc_pkg::*;
#(
    parameter int NCPU  = CPU_CNT,
    parameter int CNT_W = IGN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csr_wr,
    input  logic [ADDR_W-1:0]        csr_addr,
    input  logic [XLEN-1:0]          csr_wdata,
    input  logic [$clog2(NCPU)-1:0]  req_cpu,
    output logic [XLEN-1:0]          csr_rdata,
    input  logic                     tick_in,
    output logic [NCPU-1:0]          ipi_irq,
    output logic [NCPU-1:0]          tmr_irq
);
    localparam int CW    = CNT_W + 1;
    localparam int IDX_W = $clog2(NCPU);

    typedef struct packed {
        logic tick;
    } edge_st_t;

    edge_st_t edg_d, edg_q;
    logic     tick_rise;

    always_comb begin
        edg_d.tick = tick_in;
        tick_rise  = tick_in & ~edg_q.tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edg_q <= '0;
        else        edg_q <= edg_d;
    end

    logic                      wr_ctl;
    logic [NCPU-1:0]           wr_ign;
    logic [NCPU-1:0]           fire_w;
    logic [NCPU-1:0][CW-1:0]   cnt_w;
    logic [XLEN-1:0]           ctl_word;

    assign wr_ctl = csr_wr && (csr_addr == CTL_OFS);

    for (genvar g = 0; g < NCPU; g++) begin : g_ign
        assign wr_ign[g] = csr_wr && (csr_addr == ign_ofs(g));
        itc_ign_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_ign[g]),
            .wdata  (csr_wdata[CNT_W-1:0]),
            .step   (tick_rise),
            .cnt_o  (cnt_w[g]),
            .fire_o (fire_w[g])
        );
    end

    itc_ctl_reg #(.NCPU(NCPU)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctl),
        .wdata  (csr_wdata),
        .fire   (fire_w),
        .word_o (ctl_word),
        .ipi_o  (ipi_irq),
        .tmr_o  (tmr_irq)
    );

    always_comb begin
        csr_rdata = '0;
        if (csr_addr == CTL_OFS) begin
            csr_rdata              = ctl_word;
            csr_rdata[IDX_W-1:0]   = ctl_word[IDX_W-1:0] | req_cpu;
        end
        for (int i = 0; i < NCPU; i++) begin
            if (csr_addr == ign_ofs(i)) begin
                csr_rdata = {{(XLEN-CW){1'b0}}, cnt_w[i]};
            end
        end
    end
endmodule

// File: rtl/itc_chk.sv
module itc_chk
    import itc_pkg::*;
#(
    parameter int NCPU  = CPU_CNT,
    parameter int CNT_W = IGN_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         csr_wr,
    input logic [ADDR_W-1:0]            csr_addr,
    input logic [XLEN-1:0]              csr_wdata,
    input logic [XLEN-1:0]              csr_rdata,
    input logic                         tick_in,
    input logic [NCPU-1:0]              ipi_irq,
    input logic [NCPU-1:0]              tmr_irq,
    input logic [NCPU-1:0][CNT_W:0]     cnt_all
);
    // R6
    ipi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr == CTL_OFS) |=>
        ((ipi_irq & $past(csr_wdata[IPR_LSB +: NCPU])) == $past(csr_wdata[IPR_LSB +: NCPU])));

    // R1
    rev_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == CTL_OFS) |-> csr_rdata[35]);

    // R10
    tick_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && $past(tick_in) && !csr_wr) |=> $stable(tmr_irq));

    // R9
    tmr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_irq & ~$past(tmr_irq)) != '0) |-> $past(tick_in));

    // R7
    tmr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !tick_in) |=> ((tmr_irq & ~$past(tmr_irq)) == '0));

    for (genvar g = 0; g < NCPU; g++) begin : g_cnt
        // R8
        ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_wr && csr_addr == ign_ofs(g)) |=> !cnt_all[g][CNT_W]);
    end
endmodule

bind ipi_timer_ctrl itc_chk #(.NCPU(NCPU), .CNT_W(CNT_W)) u_itc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .tick_in   (tick_in),
    .ipi_irq   (ipi_irq),
    .tmr_irq   (tmr_irq),
    .cnt_all   (cnt_w)
);

// File: tb/test_ipi_timer_ctrl.sv
module test_ipi_timer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [1:0]  req_cpu = 2'd2;
    logic [63:0] csr_rdata;
    logic        tick_in = 1'b0;
    logic [3:0]  ipi_irq;
    logic [3:0]  tmr_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [63:0] BASE = 64'h0000_0008_0000_0000;
    localparam logic [63:0] ARB  = 64'h0000_0000_0014_0000;

    always #4 clk = ~clk;

    ipi_timer_ctrl i_ipi_timer_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .req_cpu(req_cpu), .csr_rdata(csr_rdata),
        .tick_in(tick_in), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v);
        @(negedge clk);
        csr_addr = a;
        #1 v = csr_rdata;
    endtask

    task automatic tick(input int hold);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (hold) @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(12'h080, v); chk("R1 ctl", v, BASE | 64'd2);
        for (int i = 0; i < 4; i++) begin
            logic [11:0] a;
            a = (i == 0) ? 12'h380 : (i == 1) ? 12'h3C0 : (i == 2) ? 12'h700 : 12'h740;
            rd(a, v); chk("R1 cnt", v, 64'd0);
        end
        chk("R1 irq", {56'd0, ipi_irq, tmr_irq}, 64'd0);
    endtask

    task automatic t_cpu_user();
        logic [63:0] v;
        req_cpu = 2'd3;
        rd(12'h080, v); chk("R2 idx3", v, BASE | 64'd3);
        wr(12'h080, 64'h0000_0F00_0000_0000);
        req_cpu = 2'd1;
        rd(12'h080, v); chk("R2 usrF", v, BASE | 64'h0000_0F00_0000_0001);
        wr(12'h080, 64'h0000_0500_0000_0000);
        rd(12'h080, v); chk("R2 usr5", v, BASE | 64'h0000_0500_0000_0001);
        req_cpu = 2'd2;
    endtask

    task automatic t_ipi();
        logic [63:0] v;
        wr(12'h080, 64'h5000);
        chk("R6 ipi set", {60'd0, ipi_irq}, 64'h5);
        rd(12'h080, v); chk("R6 ctl", v, BASE | 64'h502);
        wr(12'h080, 64'h100);
        chk("R3 ipi clr", {60'd0, ipi_irq}, 64'h4);
        wr(12'h080, 64'h1100);
        chk("R6 set wins", {60'd0, ipi_irq}, 64'h5);
        wr(12'h080, 64'h1000_0000);
        rd(12'h080, v); chk("R3 bit28", v, BASE | 64'h502);
        wr(12'h080, 64'hF00);
        chk("R3 ipi all", {60'd0, ipi_irq}, 64'h0);
    endtask

    task automatic t_arb();
        logic [63:0] v;
        wr(12'h080, 64'h3_0000);
        rd(12'h080, v); chk("R5 first", v, BASE | 64'h3_0002);
        wr(12'h080, 64'h4_0000);
        rd(12'h080, v); chk("R5 held", v, BASE | 64'h3_0002);
        wr(12'h080, 64'hA0_0000);
        rd(12'h080, v); chk("R4 w1s", v, BASE | 64'hA3_0002);
        wr(12'h080, 64'h14_0000);
        rd(12'h080, v); chk("R4 clr", v, BASE | ARB | 64'd2);
    endtask

    task automatic t_ticks();
        logic [63:0] v;
        wr(12'h380, 64'h100);
        wr(12'h3C0, 64'hFF00_0002);
        wr(12'h700, 64'h100);
        wr(12'h740, 64'h100);
        rd(12'h3C0, v); chk("R8 low bits", v, 64'h2);
        tick(1);
        rd(12'h3C0, v); chk("R9 dec", v, 64'h1);
        tick(3);
        rd(12'h3C0, v); chk("R10 level", v, 64'h0);
        chk("R10 no irq", {60'd0, tmr_irq}, 64'h0);
        tick(1);
        rd(12'h3C0, v); chk("R9 wrap", v, 64'h1FF_FFFF);
        chk("R9 irq", {60'd0, tmr_irq}, 64'h2);
        rd(12'h080, v); chk("R9 flag", v, BASE | ARB | 64'h22);
        rd(12'h380, v); chk("R9 other", v, 64'hFD);
        tick(1);
        rd(12'h3C0, v); chk("R9 sticky", v, 64'h1FF_FFFE);
    endtask

    task automatic t_tmr_clear();
        logic [63:0] v;
        wr(12'h080, 64'h0);
        chk("R7 keep", {60'd0, tmr_irq}, 64'h2);
        rd(12'h080, v); chk("R7 flag kept", v, BASE | ARB | 64'h22);
        wr(12'h080, 64'h10);
        chk("R7 other clr", {60'd0, tmr_irq}, 64'h2);
        wr(12'h080, 64'h20);
        chk("R7 clr", {60'd0, tmr_irq}, 64'h0);
        rd(12'h080, v); chk("R7 flag clr", v, BASE | ARB | 64'd2);
        wr(12'h3C0, 64'h10);
        rd(12'h3C0, v); chk("R8 ovf clr", v, 64'h10);
    endtask

    task automatic t_misc();
        logic [63:0] v;
        wr(12'h388, 64'hFFFF);
        rd(12'h388, v); chk("R11 unmapped rd", v, 64'h0);
        rd(12'h380, v); chk("R11 unmapped wr", v, 64'hFC);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 12'h700; csr_wdata = 64'h0; tick_in = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0; tick_in = 1'b0;
        rd(12'h700, v); chk("R11 wr wins", v, 64'h0);
        chk("R11 no fire", {60'd0, tmr_irq}, 64'h0);
        tick(1);
        rd(12'h700, v); chk("R9 wrap2", v, 64'h1FF_FFFF);
        chk("R9 irq2", {60'd0, tmr_irq}, 64'h4);
        rd(12'h3C0, v); chk("R9 cnt1", v, 64'hE);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cpu_user();
        t_ipi();
        t_arb();
        t_ticks();
        t_tmr_clear();
        t_misc();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule